// File: doc/BRIEF.md
# BCD Shutdown Countdown Timer

This block keeps the time left before an appliance switches itself off. The remaining time is held as four BCD digits: tens of hours, units of hours, tens of minutes and units of minutes. A slow external clock, whose period stands for one minute, is brought into the main clock domain. Each of its rising edges takes one minute off the count, with BCD borrows across the minute and hour digits.

The surrounding controller drives the enable input high while its off-timer function is on, and supplies the preset as four BCD digits. The count is loaded from the preset when the enable rises. It is loaded again each time the preset changes. When the count reaches 00:00 the finish output rises, and the controller uses it to cut power. The four remaining-time digits come straight from the count registers and can drive a display.

Top module: `shutoff_timer`

## Requirements
- R1: After a synchronous reset, all four remaining-time digits read 0 and finish is 0.
- R2: While enable is 0, the remaining time reads 0000 and finish is 0. Rising edges of the slow clock have no effect during this time.
- R3: In the first main-clock cycle in which enable is 1 after being 0, the count is loaded with the preset digits.
- R4: While enable is 1, any change of the preset digits reloads the count with the new value exactly once. The countdown then restarts from that value, and an unchanged preset causes no reload.
- R5: Each rising edge of the slow clock, seen while enabled, lowers the count by exactly one minute. A slow clock held at a steady level changes nothing.
- R6: When minute units is 0, a step sets it to 9 and borrows from minute tens. When minute tens is also 0, minute tens becomes 5 and the borrow passes to the hours (0100 steps to 0059).
- R7: When hour units is 0 and receives a borrow, it becomes 9 and hour tens is decremented (1000 steps to 0959, 2000 steps to 1959).
- R8: When the count reaches 0000 while enabled, finish goes to 1. Later slow-clock edges leave the count at 0000 with no wrap, and finish stays 1.
- R9: Finish returns to 0 when enable drops or when a nonzero preset is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main control clock |
| rst | input | 1 | Synchronous active-high reset |
| minute_clk | input | 1 | Slow clock, one period per minute, asynchronous to clk |
| enable | input | 1 | High while the off-timer function is on |
| preset_hr_tens | input | 4 | Preset, BCD tens of hours |
| preset_hr_units | input | 4 | Preset, BCD units of hours |
| preset_min_tens | input | 4 | Preset, BCD tens of minutes |
| preset_min_units | input | 4 | Preset, BCD units of minutes |
| left_hr_tens | output | 4 | Remaining time, BCD tens of hours |
| left_hr_units | output | 4 | Remaining time, BCD units of hours |
| left_min_tens | output | 4 | Remaining time, BCD tens of minutes |
| left_min_units | output | 4 | Remaining time, BCD units of minutes |
| finish | output | 1 | High once the remaining time reaches zero |

## Verification
The assertions check several rules on every cycle:
- A disabled block shows a cleared count and no finish.
- The count holds still unless a tick or a reload occurs.
- A reload places the preset value in the count.
- A zero count stays at zero until the next reload.
- The minute units digit steps down, or wraps to 9, on each tick.
- Finish is never high with a nonzero count.
- A synchronised tick lasts one cycle.

Only the bench scenarios show the actual borrow results across minute tens and the hours, and the exact count after a series of slow-clock edges. They also show that finish clears on a new nonzero preset, and that ticks have no effect while disabled.

// File: rtl/shutoff_pkg.sv
package shutoff_pkg;
  localparam int DIGITS = 4;
  localparam int BCD_W  = 4;

  typedef logic [BCD_W-1:0] bcd_t;
  // index 0 is minute units, 1 minute tens, 2 hour units, 3 hour tens
  typedef bcd_t [DIGITS-1:0] bcd_time_t;

  // value a digit takes when it borrows below zero
  function automatic int wrap_val(input int idx);
    return (idx == 1) ? 5 : 9;
  endfunction
endpackage

// File: rtl/tick_sync.sv
module tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic slow_in,
  output logic tick
);
  logic [STAGES:0] shift_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
      tick    <= 1'b0;
    end else begin
      shift_q <= {shift_q[STAGES-1:0], slow_in};
      tick    <= shift_q[STAGES-1] & ~shift_q[STAGES];
    end
  end

  // one pulse per slow rising edge
  p_tick_single_r5: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/reload_detect.sv
module reload_detect
  import shutoff_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      enable,
  input  bcd_time_t preset,
  output logic      load
);
  bcd_time_t prev_q;
  logic      en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      en_q   <= 1'b0;
    end else begin
      prev_q <= preset;
      en_q   <= enable;
    end
  end

  assign load = enable & (~en_q | (preset != prev_q));

  // a reload does not repeat on an unchanged preset
  p_one_reload_r4: assert property (@(posedge clk) disable iff (rst)
    (load && enable) |=> (!load || (preset != $past(preset)) || !enable));
endmodule

// File: rtl/bcd_down_counter.sv
module bcd_down_counter
  import shutoff_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      enable,
  input  logic      load,
  input  bcd_time_t load_val,
  input  logic      tick,
  output bcd_time_t count,
  output logic      finish
);
  bcd_time_t         dec_val;
  bcd_time_t         nxt;
  logic [DIGITS-1:0] borrow;
  logic              at_zero;

  assign borrow[0] = 1'b1;
  assign at_zero   = (count == '0);

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    localparam bcd_t WRAP = bcd_t'(wrap_val(g));
    logic is_zero;
    assign is_zero    = (count[g] == '0);
    assign dec_val[g] = !borrow[g] ? count[g] :
                        (is_zero ? WRAP : count[g] - 1'b1);
    if (g < DIGITS - 1) begin : g_chain
      assign borrow[g+1] = borrow[g] & is_zero;
    end
  end

  always_comb begin
    if (!enable)               nxt = '0;
    else if (load)             nxt = load_val;
    else if (tick && !at_zero) nxt = dec_val;
    else                       nxt = count;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      finish <= 1'b0;
    end else begin
      count  <= nxt;
      finish <= enable & (nxt == '0);
    end
  end

  // count moves only on tick or reload
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (enable && !tick && !load) |=> $stable(count));
  // reload takes the preset
  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    (enable && load) |=> (count == $past(load_val)));
  // zero sticks without reload
  p_zero_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (enable && at_zero && !load) |=> (count == '0));
  // minute units steps down or wraps
  p_units_step_r6: assert property (@(posedge clk) disable iff (rst)
    (enable && tick && !load && !at_zero) |=>
      (count[0] == (($past(count[0]) == '0) ? bcd_t'(9) : $past(count[0]) - 1'b1)));
  // finish only with a zero count
  p_finish_zero_r8: assert property (@(posedge clk) disable iff (rst)
    finish |-> (count == '0));
endmodule

// File: rtl/shutoff_timer.sv
module shutoff_timer
  import shutoff_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             minute_clk,
  input  logic             enable,
  input  logic [BCD_W-1:0] preset_hr_tens,
  input  logic [BCD_W-1:0] preset_hr_units,
  input  logic [BCD_W-1:0] preset_min_tens,
  input  logic [BCD_W-1:0] preset_min_units,
  output logic [BCD_W-1:0] left_hr_tens,
  output logic [BCD_W-1:0] left_hr_units,
  output logic [BCD_W-1:0] left_min_tens,
  output logic [BCD_W-1:0] left_min_units,
  output logic             finish
);
  bcd_time_t preset;
  bcd_time_t count;
  logic      tick;
  logic      load;

  assign preset = {preset_hr_tens, preset_hr_units, preset_min_tens, preset_min_units};

  tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .slow_in(minute_clk), .tick(tick)
  );

  reload_detect u_reload (
    .clk(clk), .rst(rst), .enable(enable), .preset(preset), .load(load)
  );

  bcd_down_counter u_count (
    .clk(clk), .rst(rst), .enable(enable), .load(load), .load_val(preset),
    .tick(tick), .count(count), .finish(finish)
  );

  assign left_hr_tens   = count[3];
  assign left_hr_units  = count[2];
  assign left_min_tens  = count[1];
  assign left_min_units = count[0];

  // disabled means cleared
  p_idle_clear_r2: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (count == '0 && !finish));
endmodule

// File: tb/tb_shutoff_timer.sv
module tb_shutoff_timer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic minute_clk = 1'b0;
  logic enable = 1'b0;
  logic [3:0] p_ht = 0, p_hu = 0, p_mt = 0, p_mu = 0;
  logic [3:0] l_ht, l_hu, l_mt, l_mu;
  logic finish;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  shutoff_timer dut (
    .clk(clk), .rst(rst), .minute_clk(minute_clk), .enable(enable),
    .preset_hr_tens(p_ht), .preset_hr_units(p_hu),
    .preset_min_tens(p_mt), .preset_min_units(p_mu),
    .left_hr_tens(l_ht), .left_hr_units(l_hu),
    .left_min_tens(l_mt), .left_min_units(l_mu), .finish(finish)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] exp_t, input logic exp_f);
    total++;
    if ({l_ht, l_hu, l_mt, l_mu} !== exp_t || finish !== exp_f) begin
      bad++;
      $display("FAIL %s: actual %h fin=%b expected %h fin=%b",
               req, {l_ht, l_hu, l_mt, l_mu}, finish, exp_t, exp_f);
    end
  endtask

  task automatic set_preset(input logic [15:0] v);
    {p_ht, p_hu, p_mt, p_mu} = v;
    wait_cyc(2);
  endtask

  task automatic minute_edge();
    minute_clk = 1'b1;
    wait_cyc(6);
    minute_clk = 1'b0;
    wait_cyc(6);
  endtask

  task automatic t_reset();
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(1);
    check("R1", 16'h0000, 1'b0);
  endtask

  task automatic t_disabled();
    set_preset(16'h0030);
    minute_edge();
    minute_edge();
    check("R2", 16'h0000, 1'b0);
  endtask

  task automatic t_enable_load();
    enable = 1'b1;
    wait_cyc(2);
    check("R3", 16'h0030, 1'b0);
  endtask

  task automatic t_steps();
    for (int i = 0; i < 3; i++) minute_edge();
    check("R5", 16'h0027, 1'b0);
    minute_clk = 1'b1;
    wait_cyc(20);
    check("R5 steady high", 16'h0026, 1'b0);
    minute_clk = 1'b0;
    wait_cyc(6);
  endtask

  task automatic t_minute_borrow();
    set_preset(16'h0100);
    check("R4", 16'h0100, 1'b0);
    minute_edge();
    check("R6", 16'h0059, 1'b0);
    minute_edge();
    check("R6 no reload", 16'h0058, 1'b0);
  endtask

  task automatic t_hour_borrow();
    set_preset(16'h1000);
    minute_edge();
    check("R7 1000", 16'h0959, 1'b0);
    set_preset(16'h2000);
    minute_edge();
    check("R7 2000", 16'h1959, 1'b0);
    set_preset(16'h2400);
    minute_edge();
    check("R4 restart 2400", 16'h2359, 1'b0);
  endtask

  task automatic t_finish();
    set_preset(16'h0030);
    check("R4 reload 0030", 16'h0030, 1'b0);
    for (int i = 0; i < 29; i++) minute_edge();
    check("R8 before zero", 16'h0001, 1'b0);
    minute_edge();
    check("R8 zero", 16'h0000, 1'b1);
    minute_edge();
    check("R8 no wrap", 16'h0000, 1'b1);
  endtask

  task automatic t_clear();
    set_preset(16'h0100);
    check("R9 new preset", 16'h0100, 1'b0);
    enable = 1'b0;
    wait_cyc(2);
    check("R9 enable drop", 16'h0000, 1'b0);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_enable_load();
    t_steps();
    t_minute_borrow();
    t_hour_borrow();
    t_finish();
    t_clear();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #4000000;
    total++;
    bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule